// File: doc/BRIEF.md
# Lowest-Set-Bit Manipulation ALU

This block is a bit-manipulation execution unit for a general-purpose integer pipeline. It accepts an opcode, two source operands and a valid strobe, and on the next clock edge it registers a result together with a carry flag and a zero flag. The operations are and-not, bit-field extract, isolate lowest set bit, mask up to and including the lowest set bit, clear lowest set bit, leading-zero count and trailing-zero count. The sources are only read, so a caller can reuse both operands after the operation.

The operand width is either the full width `MAX_W` (64 by default) or a narrow 32-bit width, chosen per operation by `isWide`. In narrow mode the unit reads only the low 32 bits of each source and clears the upper part of the result. When the unit is built with `MAX_W` = 32, every operation is narrow. Both zero counters give a defined answer for an all-zero source, so software can scan bit sets that may be empty.

Top module: `lsb_alu`

## Requirements
- R1: The and-not opcode (3'd0) returns the bitwise complement of `srcA`, ANDed with `srcB`.
- R2: The isolate opcode (3'd2) returns a word that keeps only the lowest set bit of `srcA`. The result has at most one bit set.
- R3: The mask opcode (3'd3) sets the lowest set bit of `srcA` and every bit below it, and clears all higher bits. An all-zero source gives all ones across the active width.
- R4: The clear opcode (3'd4) returns `srcA` with only its lowest set bit cleared.
- R5: The extract opcode (3'd1) takes its start position from `srcB[7:0]` and its length from `srcB[15:8]`. It returns that run of bits of `srcA`, right-justified and zero-filled above.
- R6: For extract, a length of zero or a start at or beyond the active width returns zero. Field bits that lie past the top of the operand read as zero, and a length at or beyond the width keeps every bit from the start upward.
- R7: The leading-zero opcode (3'd5) and the trailing-zero opcode (3'd6) return the zero count as an unsigned number. For an all-zero source they return the active width (32 or 64).
- R8: `carryFlag` is set when the source is zero for the isolate, mask, clear and both count opcodes. It is clear for every other opcode and every nonzero source.
- R9: `zeroFlag` is set exactly when the registered result is zero.
- R10: With `isWide` low, only `srcA[31:0]` and `srcB[31:0]` are used and `result[MAX_W-1:32]` is zero.
- R11: `result`, the flags and `validOut` update on the clock edge after `validIn` is high. `validOut` is a single-cycle pulse for each accepted operation, and the outputs hold their values while `validIn` is low.
- R12: While `rstN` is low, `validOut`, `result`, `carryFlag` and `zeroFlag` are all zero.
- R13: The reserved opcode (3'd7) returns zero with `carryFlag` clear and `zeroFlag` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| validIn | input | 1 | Operation strobe |
| opcode | input | 3 | Operation select, see requirements |
| isWide | input | 1 | 1: full `MAX_W` width, 0: 32-bit |
| srcA | input | MAX_W | First source operand |
| srcB | input | MAX_W | Second source operand; extract control in bits 15:0 |
| validOut | output | 1 | Result-valid pulse |
| result | output | MAX_W | Registered result |
| carryFlag | output | 1 | Zero-source flag |
| zeroFlag | output | 1 | Result-is-zero flag |

## Verification
The bench builds the unit with its default `MAX_W` of 64, so that one elaboration covers both the full-width and the 32-bit paths. This exposes how the narrow mode differs from the wide one. Count results move from 64 to 32 for empty sets, the mask of zero stops at bit 31, and extract windows are clipped at bit 31 instead of bit 63. The narrow vectors put nonzero data in the upper source bits, so that any leak of those bits into the result or the flags shows up.

// File: rtl/lsb_alu_pkg.sv
package lsb_alu_pkg;

  typedef enum logic [2:0] {
    OP_ANDN    = 3'd0,
    OP_EXTRACT = 3'd1,
    OP_ISOLATE = 3'd2,
    OP_MASK    = 3'd3,
    OP_CLEAR   = 3'd4,
    OP_LZCNT   = 3'd5,
    OP_TZCNT   = 3'd6,
    OP_RSVD    = 3'd7
  } lsbOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic selAndn;
    logic selExtract;
    logic selIsolate;
    logic selMask;
    logic selClear;
    logic selLz;
    logic selTz;
    logic carryOnZero;
  } lsbCtrl_t;

  localparam int unsigned NARROW_W = 32;
  localparam int unsigned FIELD_W  = 8;

endpackage

// File: rtl/lsb_alu_zcount.sv
// Trailing-zero counter; an all-zero vector yields W.
module lsb_alu_zcount #(
  parameter int unsigned W = 64,
  localparam int unsigned CNT_W = $clog2(W) + 1
) (
  input  logic [W-1:0]     vec,
  output logic [CNT_W-1:0] count
);

  always_comb begin
    count = CNT_W'(W);
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) count = CNT_W'(i);
    end
  end

endmodule

// File: rtl/lsb_alu_ctrl.sv
module lsb_alu_ctrl
  import lsb_alu_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     validIn,
  input  lsbOp_e   opcode,
  output lsbCtrl_t ctrl,
  output logic     validOut
);

  always_comb begin
    ctrl = '0;
    ctrl.load = validIn;
    unique case (opcode)
      OP_ANDN:    ctrl.selAndn    = 1'b1;
      OP_EXTRACT: ctrl.selExtract = 1'b1;
      OP_ISOLATE: begin ctrl.selIsolate = 1'b1; ctrl.carryOnZero = 1'b1; end
      OP_MASK:    begin ctrl.selMask    = 1'b1; ctrl.carryOnZero = 1'b1; end
      OP_CLEAR:   begin ctrl.selClear   = 1'b1; ctrl.carryOnZero = 1'b1; end
      OP_LZCNT:   begin ctrl.selLz      = 1'b1; ctrl.carryOnZero = 1'b1; end
      OP_TZCNT:   begin ctrl.selTz      = 1'b1; ctrl.carryOnZero = 1'b1; end
      default:    ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= validIn;
  end

endmodule

// File: rtl/lsb_alu_dp.sv
module lsb_alu_dp
  import lsb_alu_pkg::*;
#(
  parameter int unsigned MAX_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  lsbCtrl_t         ctrl,
  input  logic             isWide,
  input  logic [MAX_W-1:0] srcA,
  input  logic [MAX_W-1:0] srcB,
  output logic [MAX_W-1:0] result,
  output logic             carryFlag,
  output logic             zeroFlag
);

  localparam int unsigned CNT_W = $clog2(MAX_W) + 1;

  logic             wideSel;
  logic [MAX_W-1:0] opMask;
  logic [CNT_W-1:0] activeW;
  logic [MAX_W-1:0] opA;
  logic [MAX_W-1:0] opB;
  logic             srcZero;

  generate
    if (MAX_W > NARROW_W) begin : g_dual
      assign wideSel = isWide;
    end else begin : g_narrow
      logic unusedWide;
      assign unusedWide = isWide;
      assign wideSel    = 1'b0;
    end
  endgenerate

  assign opMask  = wideSel ? '1 : MAX_W'({NARROW_W{1'b1}});
  assign activeW = wideSel ? CNT_W'(MAX_W) : CNT_W'(NARROW_W);
  assign opA     = srcA & opMask;
  assign opB     = srcB & opMask;
  assign srcZero = (opA == '0);

  // lowest-set-bit family
  logic [MAX_W-1:0] aMinus1;
  logic [MAX_W-1:0] isoVal;
  logic [MAX_W-1:0] mskVal;
  logic [MAX_W-1:0] clrVal;
  logic [MAX_W-1:0] andnVal;

  assign aMinus1 = opA - MAX_W'(1);
  assign isoVal  = opA & (~opA + MAX_W'(1));
  assign mskVal  = (opA ^ aMinus1) & opMask;
  assign clrVal  = opA & aMinus1;
  assign andnVal = ~opA & opB;

  // field extract
  logic [FIELD_W-1:0] fStart;
  logic [FIELD_W-1:0] fLen;
  logic [MAX_W-1:0]   shifted;
  logic [MAX_W-1:0]   lenMask;
  logic [MAX_W-1:0]   extVal;

  assign fStart  = opB[FIELD_W-1:0];
  assign fLen    = opB[2*FIELD_W-1:FIELD_W];
  assign shifted = ({1'b0, fStart} >= (FIELD_W+1)'(activeW)) ? '0 : (opA >> fStart);
  assign lenMask = ({1'b0, fLen} >= (FIELD_W+1)'(activeW)) ? opMask
                 : ((MAX_W'(1) << fLen) - MAX_W'(1));
  assign extVal  = shifted & lenMask;

  // zero counters: leading count is the trailing count of the
  // top-aligned operand read back to front
  logic [MAX_W-1:0] topAligned;
  logic [MAX_W-1:0] reversed;
  logic [CNT_W-1:0] tzRaw;
  logic [CNT_W-1:0] lzRaw;
  logic [MAX_W-1:0] lzVal;
  logic [MAX_W-1:0] tzVal;

  assign topAligned = wideSel ? opA : (opA << (MAX_W - NARROW_W));

  generate
    for (genvar i = 0; i < MAX_W; i++) begin : g_rev
      assign reversed[i] = topAligned[MAX_W-1-i];
    end
  endgenerate

  lsb_alu_zcount #(.W(MAX_W)) u_tz (.vec(opA),      .count(tzRaw));
  lsb_alu_zcount #(.W(MAX_W)) u_lz (.vec(reversed), .count(lzRaw));

  assign tzVal = MAX_W'(srcZero ? activeW : tzRaw);
  assign lzVal = MAX_W'(srcZero ? activeW : lzRaw);

  // result select
  logic [MAX_W-1:0] nextRes;
  logic             nextCarry;

  always_comb begin
    nextRes = '0;
    if (ctrl.selAndn)    nextRes = nextRes | andnVal;
    if (ctrl.selExtract) nextRes = nextRes | extVal;
    if (ctrl.selIsolate) nextRes = nextRes | isoVal;
    if (ctrl.selMask)    nextRes = nextRes | mskVal;
    if (ctrl.selClear)   nextRes = nextRes | clrVal;
    if (ctrl.selLz)      nextRes = nextRes | lzVal;
    if (ctrl.selTz)      nextRes = nextRes | tzVal;
    nextRes   = nextRes & opMask;
    nextCarry = ctrl.carryOnZero & srcZero;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result    <= '0;
      carryFlag <= 1'b0;
      zeroFlag  <= 1'b0;
    end else if (ctrl.load) begin
      result    <= nextRes;
      carryFlag <= nextCarry;
      zeroFlag  <= (nextRes == '0);
    end
  end

endmodule

// File: rtl/lsb_alu.sv
module lsb_alu
  import lsb_alu_pkg::*;
#(
  parameter int unsigned MAX_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             validIn,
  input  logic [2:0]       opcode,
  input  logic             isWide,
  input  logic [MAX_W-1:0] srcA,
  input  logic [MAX_W-1:0] srcB,
  output logic             validOut,
  output logic [MAX_W-1:0] result,
  output logic             carryFlag,
  output logic             zeroFlag
);

  lsbCtrl_t ctrl;

  lsb_alu_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .validIn  (validIn),
    .opcode   (lsbOp_e'(opcode)),
    .ctrl     (ctrl),
    .validOut (validOut)
  );

  lsb_alu_dp #(.MAX_W(MAX_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .isWide    (isWide),
    .srcA      (srcA),
    .srcB      (srcB),
    .result    (result),
    .carryFlag (carryFlag),
    .zeroFlag  (zeroFlag)
  );

endmodule

// File: rtl/lsb_alu_chk.sv
module lsb_alu_chk #(
  parameter int unsigned MAX_W = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             validIn,
  input logic [2:0]       opcode,
  input logic             isWide,
  input logic [MAX_W-1:0] srcA,
  input logic             validOut,
  input logic [MAX_W-1:0] result,
  input logic             carryFlag,
  input logic             zeroFlag
);

  // R11
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);

  // R11
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !validOut);

  // R11
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> $stable(result) && $stable(carryFlag) && $stable(zeroFlag));

  // R9
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> (zeroFlag == (result == '0)));

  // R2
  isolate_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && opcode == 3'd2) |=> $onehot0(result));

  // R8
  isolate_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && opcode == 3'd2) |=> (carryFlag == (result == '0)));

  // R4
  clear_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && isWide && opcode == 3'd4 && srcA != '0) |=>
      ($countones(result) + 1 == $countones($past(srcA))));

  // R13
  reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && opcode == 3'd7) |=> (result == '0 && !carryFlag && zeroFlag));

  generate
    if (MAX_W > 32) begin : g_upper
      // R10
      narrow_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
        (validIn && !isWide) |=> (result[MAX_W-1:32] == '0));
    end
  endgenerate

endmodule

bind lsb_alu lsb_alu_chk #(.MAX_W(MAX_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .validIn   (validIn),
  .opcode    (opcode),
  .isWide    (isWide),
  .srcA      (srcA),
  .validOut  (validOut),
  .result    (result),
  .carryFlag (carryFlag),
  .zeroFlag  (zeroFlag)
);

// File: tb/lsb_alu_test.sv
module lsb_alu_test;

  localparam int unsigned MAX_W = 64;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned NV = 28;
  localparam int unsigned VW = 4 + 3 + 1 + 3 * MAX_W + 2;

  // {reqTag[3:0], opcode[2:0], isWide, srcA, srcB, expResult, expCarry, expZero}
  localparam logic [VW-1:0] VECS [NV] = '{
    {4'd1,  3'd0, 1'b1, 64'h00FF_00FF_00FF_00FF, 64'h0F0F_0F0F_0F0F_0F0F, 64'h0F00_0F00_0F00_0F00, 1'b0, 1'b0}, // R1
    {4'd1,  3'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_1234, 64'h0,                   1'b0, 1'b1}, // R1 R9
    {4'd2,  3'd2, 1'b1, 64'h0000_0000_0000_0B00, 64'h0,                   64'h0000_0000_0000_0100, 1'b0, 1'b0}, // R2
    {4'd8,  3'd2, 1'b1, 64'h0,                   64'h0,                   64'h0,                   1'b1, 1'b1}, // R8
    {4'd2,  3'd2, 1'b1, 64'h8000_0000_0000_0000, 64'h0,                   64'h8000_0000_0000_0000, 1'b0, 1'b0}, // R2
    {4'd3,  3'd3, 1'b1, 64'h0000_0000_0000_0058, 64'h0,                   64'h0000_0000_0000_000F, 1'b0, 1'b0}, // R3
    {4'd3,  3'd3, 1'b1, 64'h0,                   64'h0,                   64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0}, // R3 R8
    {4'd4,  3'd4, 1'b1, 64'h0000_0000_0000_0058, 64'h0,                   64'h0000_0000_0000_0050, 1'b0, 1'b0}, // R4
    {4'd4,  3'd4, 1'b1, 64'h8000_0000_0000_0000, 64'h0,                   64'h0,                   1'b0, 1'b1}, // R4 R9
    {4'd7,  3'd5, 1'b1, 64'h0000_0001_0000_0000, 64'h0,                   64'd31,                  1'b0, 1'b0}, // R7
    {4'd7,  3'd5, 1'b1, 64'h0,                   64'h0,                   64'd64,                  1'b1, 1'b0}, // R7 R8
    {4'd7,  3'd6, 1'b1, 64'h8000_0000_0000_0000, 64'h0,                   64'd63,                  1'b0, 1'b0}, // R7
    {4'd7,  3'd6, 1'b1, 64'h0,                   64'h0,                   64'd64,                  1'b1, 1'b0}, // R7 R8
    {4'd10, 3'd5, 1'b0, 64'hFFFF_FFFF_0000_8000, 64'h0,                   64'd16,                  1'b0, 1'b0}, // R10 R7
    {4'd10, 3'd5, 1'b0, 64'hFFFF_FFFF_0000_0000, 64'h0,                   64'd32,                  1'b1, 1'b0}, // R10 R7
    {4'd10, 3'd6, 1'b0, 64'h0000_0001_0000_0000, 64'h0,                   64'd32,                  1'b1, 1'b0}, // R10 R7
    {4'd5,  3'd1, 1'b1, 64'h1234_5678_9ABC_DEF0, 64'h0000_0000_0000_0C08, 64'h0000_0000_0000_0CDE, 1'b0, 1'b0}, // R5
    {4'd6,  3'd1, 1'b1, 64'h1234_5678_9ABC_DEF0, 64'h0000_0000_0000_0004, 64'h0,                   1'b0, 1'b1}, // R6 zero length
    {4'd6,  3'd1, 1'b1, 64'h1234_5678_9ABC_DEF0, 64'h0000_0000_0000_0840, 64'h0,                   1'b0, 1'b1}, // R6 start past width
    {4'd6,  3'd1, 1'b1, 64'h1234_5678_9ABC_DEF0, 64'h0000_0000_0000_103C, 64'h0000_0000_0000_0001, 1'b0, 1'b0}, // R6 field over top
    {4'd6,  3'd1, 1'b1, 64'h1234_5678_9ABC_DEF0, 64'h0000_0000_0000_C800, 64'h1234_5678_9ABC_DEF0, 1'b0, 1'b0}, // R6 long length
    {4'd10, 3'd1, 1'b0, 64'hFFFF_FFFF_8765_4321, 64'hFFFF_0000_0000_081C, 64'h0000_0000_0000_0008, 1'b0, 1'b0}, // R10 R6
    {4'd10, 3'd1, 1'b0, 64'hFFFF_FFFF_8765_4321, 64'h0000_0000_0000_0420, 64'h0,                   1'b0, 1'b1}, // R10 R6
    {4'd10, 3'd3, 1'b0, 64'hFFFF_FFFF_0000_0000, 64'h0,                   64'h0000_0000_FFFF_FFFF, 1'b1, 1'b0}, // R10 R3
    {4'd10, 3'd2, 1'b0, 64'hABCD_0000_0000_0010, 64'h0,                   64'h0000_0000_0000_0010, 1'b0, 1'b0}, // R10 R2
    {4'd10, 3'd0, 1'b0, 64'h0,                   64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 1'b0, 1'b0}, // R10 R1
    {4'd13, 3'd7, 1'b1, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0005, 64'h0,                   1'b0, 1'b1}, // R13
    {4'd8,  3'd4, 1'b0, 64'h0000_0003_0000_0000, 64'h0,                   64'h0,                   1'b1, 1'b1}  // R8 R10
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             validIn = 1'b0;
  logic [2:0]       opcode = '0;
  logic             isWide = 1'b1;
  logic [MAX_W-1:0] srcA = '0;
  logic [MAX_W-1:0] srcB = '0;
  logic             validOut;
  logic [MAX_W-1:0] result;
  logic             carryFlag;
  logic             zeroFlag;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  lsb_alu #(.MAX_W(MAX_W)) uut (
    .clk       (clk),
    .rstN      (rstN),
    .validIn   (validIn),
    .opcode    (opcode),
    .isWide    (isWide),
    .srcA      (srcA),
    .srcB      (srcB),
    .validOut  (validOut),
    .result    (result),
    .carryFlag (carryFlag),
    .zeroFlag  (zeroFlag)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [MAX_W+2:0] act, input logic [MAX_W+2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one operation for one cycle; return at the negedge after the capture edge
  task automatic issue(input logic [2:0] op, input logic wide, input logic [MAX_W-1:0] a,
                       input logic [MAX_W-1:0] b);
    @(negedge clk);
    opcode = op; isWide = wide; srcA = a; srcB = b; validIn = 1'b1;
    @(negedge clk);
    validIn = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R12: outputs while reset is held
    repeat (3) @(negedge clk);
    check("R12 reset", {validOut, carryFlag, zeroFlag, result}, '0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VECS[i];
      issue(v[VW-5 -: 3], v[VW-8], v[3*MAX_W+1 -: MAX_W], v[2*MAX_W+1 -: MAX_W]);
      checks++;
      if ({validOut, result, carryFlag, zeroFlag} !== {1'b1, v[MAX_W+1:0]}) begin
        failures++;
        $display("FAIL R%0d vector %0d actual=%h c=%b z=%b v=%b expected=%h c=%b z=%b",
                 v[VW-1 -: 4], i, result, carryFlag, zeroFlag, validOut,
                 v[MAX_W+1:2], v[1], v[0]);
      end
    end

    // R11: the valid pulse lasts one cycle and the outputs hold while idle
    issue(3'd6, 1'b1, 64'h0000_0000_0000_0040, '0);
    check("R11 first result", {validOut, carryFlag, zeroFlag, result}, {3'b100, 64'd6});
    @(negedge clk);
    opcode = 3'd0; srcA = '0; srcB = '1;
    @(negedge clk);
    check("R11 hold", {validOut, carryFlag, zeroFlag, result}, {3'b000, 64'd6});

    // R11: back-to-back operations each land one cycle later
    @(negedge clk);
    opcode = 3'd4; isWide = 1'b1; srcA = 64'h0000_0000_0000_0006; validIn = 1'b1;
    @(negedge clk);
    check("R11 back-to-back first", {validOut, carryFlag, zeroFlag, result}, {3'b100, 64'h4});
    opcode = 3'd3; srcA = 64'h0000_0000_0000_0010;
    @(negedge clk);
    validIn = 1'b0;
    check("R11 back-to-back second", {validOut, carryFlag, zeroFlag, result}, {3'b100, 64'h1F});

    // R12: asynchronous reset clears the registered outputs
    issue(3'd3, 1'b1, '0, '0);
    #(CLK_PERIOD / 4);
    rstN = 1'b0;
    #(CLK_PERIOD / 8);
    check("R12 async reset", {validOut, carryFlag, zeroFlag, result}, '0);
    @(negedge clk);
    rstN = 1'b1;

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule